// File: doc/BRIEF.md
# Grouped Pin Interrupt Summary with End-of-Interrupt and Status Blanking

This block gathers the pending flags of up to 184 pins into one summary vector and drives a single interrupt line to the host. Each summary bit stands for a group of four neighbouring pins and is set when any of them is pending. The host reads the vector as two 32-bit words and uses it to find which group needs service.

A master control register holds an end-of-interrupt (EOI) strobe bit and a status-blanking setup. The blanking setup is an enable bit plus a 12-bit length. When blanking is enabled and a pin's debounce configuration is written, the block starts a window that lasts a set number of reference-clock ticks. During that window, status generation is held off for every pin, and each pin's interrupt-enable bit reads back as 0. The per-pin detectors and the bus address decoder sit outside this block. Access uses a simple write strobe with an address and a combinational read-data path.

Top module: `irq_summary_top`

## Requirements
- R1: Summary bit g is registered one cycle after the inputs. It is the OR of pending flags 4g, 4g+1, 4g+2 and 4g+3.
- R2: Reads use these addresses. Address 0 returns summary bits 31:0. Address 1 returns summary bits 63:32. Summary bits 46 to 63 always read 0, so bits 31:14 at address 1 are 0. Address 3 reads 0.
- R3: `host_irq` is high exactly when the summary vector is non-zero and no EOI hold-off is active.
- R4: Writing address 2 with bit 13 set causes an EOI. `host_irq` is then low for the next cycle only. After that it follows the summary again.
- R5: Address 2 reads the blanking length in bits 11:0 and the blanking enable in bit 12. Bit 13, the EOI bit, always reads 0, as do bits 31:14. A write to address 2 updates bits 11:0 and bit 12.
- R6: A debounce-configuration write strobe opens the blanking window when the enable is 1 and the length is non-zero. While the window is open, the summary loads 0, so both status words read 0 and `host_irq` stays low.
- R7: While the window is open, `pin_ien_rd` is all zeros. Otherwise it equals `pin_ien`.
- R8: The window stays open until `ref_tick` has been seen the programmed number of times after it opened. A new debounce write while the window is open restarts the count.
- R9: A debounce write opens no window when the enable is 0 or the length is 0.
- R10: After a synchronous active-low reset, the summary, the master fields and the EOI hold-off are all 0, and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_pend | input | 184 | Pending flag of each pin |
| pin_ien | input | 184 | Stored interrupt-enable bit of each pin |
| ref_tick | input | 1 | One-cycle pulse per reference-clock tick |
| dbcfg_wr | input | 1 | Strobe: a debounce configuration write to any pin |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| host_irq | output | 1 | Interrupt to the host |
| pin_ien_rd | output | 184 | Enable bits as the host reads them back |

## Verification
Single-pin patterns are applied one at a time. Pin 0 and pin 3 test that both land in the same group. Pins 127 and 128 test that the group crosses cleanly from the low word into the high word. Pin 183 exercises the top group, bit 13 of the high word. Blanking is run with lengths 3, 0 and with the enable cleared, and one run restarts the window midway. These runs separate a correct tick count from off-by-one errors and from a window that ignores its enable. A long random run mixes sparse pending patterns, ticks, EOI writes and reconfiguration against a behavioural model, which catches ordering mistakes between the EOI hold-off, window loading and summary capture.

// File: rtl/irq_summary_pkg.sv
// Package: shared register addresses and master-register bit positions
// for the grouped interrupt summary block.
package irq_summary_pkg;
    typedef enum logic [1:0] {
        ADDR_STAT_LO = 2'd0,
        ADDR_STAT_HI = 2'd1,
        ADDR_MASTER  = 2'd2,
        ADDR_SPARE   = 2'd3
    } reg_addr_e;

    localparam int MST_EN_BIT  = 12;
    localparam int MST_EOI_BIT = 13;
endpackage

// File: rtl/irq_group_summary.sv
// irq_group_summary: ORs each group of GRP consecutive pending flags into one
// summary bit and registers the result. Bits at or above VALID_GROUPS are
// tied to 0. While blank is high, the registered summary loads all zeros.
// Assumes NUM_PINS <= VALID_GROUPS*GRP (pins beyond that are not summarised).
module irq_group_summary #(
    parameter int NUM_PINS     = 184,
    parameter int GRP          = 4,
    parameter int VALID_GROUPS = 46,
    parameter int SUM_W        = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pend,
    input  logic                blank,
    output logic [SUM_W-1:0]    sum_q
);
    localparam int RAW_GROUPS = (NUM_PINS + GRP - 1) / GRP;
    localparam int USED       = (RAW_GROUPS < VALID_GROUPS) ? RAW_GROUPS : VALID_GROUPS;

    logic [SUM_W-1:0] sum_d;

    for (genvar g = 0; g < SUM_W; g++) begin : g_grp
        if (g < USED) begin : g_used
            logic [GRP-1:0] members;
            for (genvar j = 0; j < GRP; j++) begin : g_mem
                if (g * GRP + j < NUM_PINS) begin : g_real
                    assign members[j] = pend[g*GRP+j];
                end else begin : g_pad
                    assign members[j] = 1'b0;
                end
            end
            assign sum_d[g] = |members;
        end else begin : g_unused
            assign sum_d[g] = 1'b0;
        end
    end

    // Capture the grouped flags, or zeros while status is blanked.
    always_ff @(posedge clk) begin
        if (!rst_n)     sum_q <= '0;
        else if (blank) sum_q <= '0;
        else            sum_q <= sum_d;
    end
endmodule

// File: rtl/irq_blank_timer.sv
// irq_blank_timer: counts the status-blanking window. A configuration write
// reloads the counter with len when blanking is enabled and len is non-zero.
// Each ref_tick then takes one count away. blank is high while the count is
// non-zero. A reload takes priority over a tick in the same cycle.
module irq_blank_timer #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             mask_en,
    input  logic [LEN_W-1:0] len,
    input  logic             tick,
    output logic             blank
);
    logic [LEN_W-1:0] cnt_q;

    // Reload on a qualifying configuration write, otherwise count ticks down.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cnt_q <= '0;
        else if (cfg_wr && mask_en && len != '0)   cnt_q <= len;
        else if (tick && cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
    end

    assign blank = (cnt_q != '0);
endmodule

// File: rtl/irq_master_regs.sv
// irq_master_regs: holds the blanking enable and length, and turns an EOI
// write into a one-cycle hold-off pulse. EOI is a strobe and is not stored
// as a readable field.
module irq_master_regs
    import irq_summary_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              mask_en,
    output logic [LEN_W-1:0]  len,
    output logic              eoi_hold
);
    logic mst_wr;
    assign mst_wr = reg_wr && (reg_addr == ADDR_MASTER);

    // Store the blanking fields on a master write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_en <= 1'b0;
            len     <= '0;
        end else if (mst_wr) begin
            mask_en <= reg_wdata[MST_EN_BIT];
            len     <= reg_wdata[LEN_W-1:0];
        end
    end

    // Raise the hold-off for the cycle after an EOI write.
    always_ff @(posedge clk) begin
        if (!rst_n) eoi_hold <= 1'b0;
        else        eoi_hold <= mst_wr && reg_wdata[MST_EOI_BIT];
    end
endmodule

// File: rtl/irq_summary_top.sv
// irq_summary_top: grouped pin interrupt summary with the host interrupt line,
// EOI hold-off, status blanking window and enable-readback masking.
// Assumes dbcfg_wr is a one-cycle pulse per configuration write and ref_tick
// is a one-cycle pulse per reference-clock tick, both synchronous to clk.
module irq_summary_top
    import irq_summary_pkg::*;
#(
    parameter int NUM_PINS     = 184,
    parameter int GRP          = 4,
    parameter int VALID_GROUPS = 46,
    parameter int LEN_W        = 12,
    parameter int WORD_W       = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_pend,
    input  logic [NUM_PINS-1:0] pin_ien,
    input  logic                ref_tick,
    input  logic                dbcfg_wr,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                host_irq,
    output logic [NUM_PINS-1:0] pin_ien_rd
);
    localparam int SUM_W = 2 * WORD_W;

    logic [SUM_W-1:0] sum_q;
    logic             blank;
    logic             mask_en;
    logic [LEN_W-1:0] len;
    logic             eoi_hold;

    irq_master_regs #(.LEN_W(LEN_W), .WORD_W(WORD_W)) u_mst (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mask_en(mask_en), .len(len), .eoi_hold(eoi_hold)
    );

    irq_blank_timer #(.LEN_W(LEN_W)) u_blank (
        .clk(clk), .rst_n(rst_n), .cfg_wr(dbcfg_wr), .mask_en(mask_en),
        .len(len), .tick(ref_tick), .blank(blank)
    );

    irq_group_summary #(
        .NUM_PINS(NUM_PINS), .GRP(GRP), .VALID_GROUPS(VALID_GROUPS), .SUM_W(SUM_W)
    ) u_sum (
        .clk(clk), .rst_n(rst_n), .pend(pin_pend), .blank(blank), .sum_q(sum_q)
    );

    // Read mux over the two status words and the master register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_STAT_LO: reg_rdata = sum_q[WORD_W-1:0];
            ADDR_STAT_HI: reg_rdata = sum_q[SUM_W-1:WORD_W];
            ADDR_MASTER: begin
                reg_rdata[LEN_W-1:0]  = len;
                reg_rdata[MST_EN_BIT] = mask_en;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign host_irq   = (|sum_q) && !eoi_hold;
    assign pin_ien_rd = blank ? '0 : pin_ien;
endmodule

// File: rtl/irq_summary_chk.sv
// irq_summary_chk: protocol checks for irq_summary_top, attached by bind.
module irq_summary_chk
    import irq_summary_pkg::*;
#(
    parameter int NUM_PINS = 184,
    parameter int WORD_W   = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [1:0]            reg_addr,
    input logic [WORD_W-1:0]     reg_wdata,
    input logic                  cfg_wr,
    input logic                  tick,
    input logic                  mask_en,
    input logic                  blank,
    input logic [2*WORD_W-1:0]   sum_q,
    input logic                  host_irq,
    input logic [NUM_PINS-1:0]   en_rd
);
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (sum_q != '0)); // R3

    AST_EOI_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_MASTER && reg_wdata[MST_EOI_BIT]) |=> !host_irq); // R4

    AST_BLANK_CLEARS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (sum_q == '0)); // R6

    AST_ENABLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (en_rd == '0)); // R7

    AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !tick) |=> blank); // R8

    AST_NO_WINDOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && !(cfg_wr && mask_en)) |=> !blank); // R9
endmodule

bind irq_summary_top irq_summary_chk #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cfg_wr(dbcfg_wr), .tick(ref_tick), .mask_en(mask_en),
    .blank(blank), .sum_q(sum_q), .host_irq(host_irq), .en_rd(pin_ien_rd)
);

// File: tb/sim_irq_summary_top.sv
module sim_irq_summary_top;
    localparam int NP = 184;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_pend = '0;
    logic [NP-1:0] pin_ien = '0;
    logic          ref_tick = 1'b0;
    logic          dbcfg_wr = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          host_irq;
    logic [NP-1:0] pin_ien_rd;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_summary_top u0 (
        .clk(clk), .rst_n(rst_n), .pin_pend(pin_pend), .pin_ien(pin_ien),
        .ref_tick(ref_tick), .dbcfg_wr(dbcfg_wr), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_irq(host_irq), .pin_ien_rd(pin_ien_rd)
    );

    // Behavioural reference model
    bit [63:0] m_sum;
    int        m_cnt;
    bit        m_hold;
    int        m_len;
    bit        m_en;
    bit        started = 0;

    always @(posedge clk) begin
        bit [63:0] ns;
        bit        mw;
        started = 1;
        if (!rst_n) begin
            m_sum = 0; m_cnt = 0; m_hold = 0; m_len = 0; m_en = 0;
        end else begin
            ns = 0;
            if (m_cnt == 0)
                for (int i = 0; i < NP; i++) if (pin_pend[i]) ns[i/4] = 1;
            mw = reg_wr && reg_addr == 2'd2;
            if (dbcfg_wr && m_en && m_len != 0) m_cnt = m_len;
            else if (ref_tick && m_cnt > 0) m_cnt = m_cnt - 1;
            m_hold = mw && reg_wdata[13];
            if (mw) begin m_len = int'(reg_wdata[11:0]); m_en = reg_wdata[12]; end
            m_sum = ns;
        end
    end

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_sum[31:0];
            2'd1: return m_sum[63:32];
            2'd2: return {18'd0, 1'b0, m_en, m_len[11:0]};
            default: return 32'd0;
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk("R3 host_irq vs model", NP'(host_irq), NP'((m_sum != 0) && !m_hold));
            chk("R2 R5 reg_rdata vs model", NP'(reg_rdata), NP'(exp_rd(reg_addr)));
            chk("R7 pin_ien_rd vs model", pin_ien_rd, (m_cnt != 0) ? '0 : pin_ien);
        end
    end

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #2;
            reg_wr = 0; dbcfg_wr = 0; ref_tick = 0;
        end
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a; #1;
        chk(tag, NP'(reg_rdata), NP'(exp));
    endtask

    task automatic wr_master(input logic [31:0] d);
        @(negedge clk); #2;
        reg_wr = 1; reg_addr = 2'd2; reg_wdata = d;
        step(1);
    endtask

    task automatic db_write();
        @(negedge clk); #2;
        dbcfg_wr = 1;
        step(1);
    endtask

    task automatic tick_once();
        @(negedge clk); #2;
        ref_tick = 1;
        step(1);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        pin_pend = {NP{1'b1}};
        step(3);
        // R10: reset state
        rd("R10 status lo after reset", 2'd0, 0);
        rd("R10 master after reset", 2'd2, 0);
        chk("R10 host_irq after reset", NP'(host_irq), '0);
        pin_pend = '0;
        rst_n = 1;
        step(2);

        // R1 R2: single pins
        pin_pend[0] = 1; step(2);
        rd("R1 pin0 -> group0", 2'd0, 32'h1);
        chk("R3 irq with pending", NP'(host_irq), NP'(1));
        pin_pend = '0; pin_pend[3] = 1; step(2);
        rd("R1 pin3 -> group0", 2'd0, 32'h1);
        pin_pend = '0; pin_pend[4] = 1; step(2);
        rd("R1 pin4 -> group1", 2'd0, 32'h2);
        pin_pend = '0; pin_pend[127] = 1; step(2);
        rd("R1 pin127 -> group31", 2'd0, 32'h8000_0000);
        rd("R2 hi word empty", 2'd1, 0);
        pin_pend = '0; pin_pend[128] = 1; step(2);
        rd("R2 pin128 -> hi bit0", 2'd1, 32'h1);
        pin_pend = '0; pin_pend[183] = 1; step(2);
        rd("R2 pin183 -> hi bit13", 2'd1, 32'h2000);
        pin_pend = {NP{1'b1}}; step(2);
        rd("R2 upper bits zero", 2'd1, 32'h0000_3FFF);
        rd("R2 spare address", 2'd3, 0);

        // R4: EOI hold-off for one cycle
        wr_master(32'h2000);
        chk("R4 irq low after EOI", NP'(host_irq), '0);
        rd("R5 EOI bit reads 0", 2'd2, 0);
        step(1);
        chk("R4 irq back after EOI", NP'(host_irq), NP'(1));

        // R5 R6 R7 R8: window of 3 ticks
        wr_master(32'h1003);
        rd("R5 master readback", 2'd2, 32'h1003);
        pin_ien = {NP{1'b1}};
        db_write();
        chk("R7 enable masked in window", pin_ien_rd, '0);
        step(1);
        rd("R6 status lo blanked", 2'd0, 0);
        chk("R6 irq low in window", NP'(host_irq), '0);
        tick_once(); tick_once();
        chk("R8 still open after 2 ticks", pin_ien_rd, '0);
        db_write();
        tick_once(); tick_once();
        chk("R8 restart keeps window", pin_ien_rd, '0);
        tick_once();
        chk("R8 closed after 3rd tick", pin_ien_rd, pin_ien);
        step(1);
        rd("R6 status back after window", 2'd0, 32'hFFFF_FFFF);

        // R9: disabled or zero length
        wr_master(32'h0005);
        db_write();
        chk("R9 enable clear, no window", pin_ien_rd, pin_ien);
        wr_master(32'h1000);
        db_write();
        chk("R9 length zero, no window", pin_ien_rd, pin_ien);

        // Random mixed run
        pin_pend = '0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk); #2;
            reg_wr = 0; dbcfg_wr = 0;
            ref_tick = ($urandom_range(3) == 0);
            if ($urandom_range(7) == 0) pin_pend = '0;
            if ($urandom_range(3) == 0) pin_pend[$urandom_range(NP-1)] = 1;
            if ($urandom_range(4) == 0) pin_ien[$urandom_range(NP-1)] ^= 1'b1;
            dbcfg_wr = ($urandom_range(29) == 0);
            reg_addr = 2'($urandom_range(3));
            if ($urandom_range(19) == 0) begin
                reg_wr = 1;
                reg_wdata = {18'd0, 1'($urandom_range(1)), 1'($urandom_range(1)),
                             12'($urandom_range(6))};
            end
        end
        step(3);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule